// File: doc/BRIEF.md
# Configurable SPI Master/Slave Controller

This block is an 8-bit serial peripheral interface controller that acts either as the bus master or as a slave. Software reaches it through a small register port with three locations: a configuration word, a status word and a data register. In master mode a write to the data register starts a transfer. The controller derives SCK from the system clock through a selectable divider, shifts the byte out on MOSI and fills the same register from MISO.

In slave mode the controller follows an external SCK, but only while the external select line is low. It drives MISO only in that state and shows an output enable for the pad. Bit order, clock polarity and clock phase apply to both roles. If the select line is pulled low while master mode is set, the controller drops back to slave and raises the completion flag.

Top module: `spi_ctrl`

## Requirements
- R1: After reset the configuration reads 0x00, the status reads 0x00, SCK, MOSI and the MISO output enable are all low.
- R2: In master mode a data-register write while idle starts an 8-bit full-duplex transfer. Afterwards the data register holds the byte received on MISO, and MOSI carried the written byte.
- R3: Configuration bit 2 sets the idle SCK level (1 = idle high). SCK rests at that level whenever no transfer runs.
- R4: Configuration bit 3 = 0 samples on the leading SCK edge and changes data on the trailing edge. Bit 3 = 1 changes data on the leading edge and samples on the trailing edge. Bit 0 = 1 sends bit 0 of the byte first, and bit 0 = 0 sends bit 7 first. The same order applies to reception.
- R5: Configuration bits 5:4 select an SCK period of 4, 16, 64 or 128 system clocks for codes 0 to 3. Each SCK half-period lasts half that many clocks, and a master transfer has exactly 16 SCK edges.
- R6: Configuration bit 6 halves the selected period, so code 0 gives 2 clocks. The rate bits and bit 6 do not change slave operation, which follows the external SCK only.
- R7: Status bit 7 is set after the eighth sampling edge. It clears when software reads the status while the bit is set and then reads or writes the data register.
- R8: A data-register write during a master transfer leaves the transfer and its byte unchanged and sets status bit 6. Status bit 6 clears by the same status-then-data sequence as bit 7.
- R9: While configuration bit 1 (master) is set, a low select input clears bit 1 and sets status bit 7.
- R10: A slave with the select input high ignores SCK and keeps the MISO output enable low. A falling select input restarts its bit count, so an aborted partial transfer does not corrupt the next one.
- R11: In a slave with bit 3 = 0, the first data bit is on MISO, with the output enable high, within a few clocks of the select input falling and before the first SCK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 configuration, 1 status, 2 data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (arms and clears the status flags) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| sck_out | output | 1 | Serial clock driven as master |
| sck_in | input | 1 | Serial clock received as slave |
| ss_n_in | input | 1 | Active-low select input |
| mosi_out | output | 1 | Master data out |
| mosi_in | input | 1 | Slave data in |
| miso_out | output | 1 | Slave data out |
| miso_oe | output | 1 | Output enable for the slave data pad |
| miso_in | input | 1 | Master data in |

## Verification
In master mode the first SCK edge comes exactly one half-period after the clock edge that takes the data write, and each later edge follows one half-period on. The bench therefore waits 16 half-periods plus a margin before it reads status and data. It takes MOSI from the sample one clock before each sampling edge, because a shift can land on that same edge. The slave inputs pass through a two-stage synchronizer plus an edge register, so every slave result lags its pin event by about three clocks. The bench holds each SCK half-period for eight clocks and reads MISO only at the end of that window, after the output has settled. The status flags and the mode-fault clear are registered, so they are read one clock or more after their cause.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;

  localparam int DIV_W  = 8;
  localparam int HALF_W = DIV_W - 1;

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // configuration word, bit 0 at the bottom
  typedef struct packed {
    logic       dbl;        // bit 6
    logic [1:0] rate;       // bits 5:4
    logic       cpha;       // bit 3
    logic       cpol;       // bit 2
    logic       master;     // bit 1
    logic       lsb_first;  // bit 0
  } spi_cfg_t;

  localparam int CFG_W = $bits(spi_cfg_t);

  // full SCK period in system clocks
  function automatic logic [DIV_W-1:0] sck_period(input logic [1:0] rate, input logic dbl);
    logic [DIV_W-1:0] base;
    case (rate)
      2'd0:    base = DIV_W'(4);
      2'd1:    base = DIV_W'(16);
      2'd2:    base = DIV_W'(64);
      default: base = DIV_W'(128);
    endcase
    return dbl ? (base >> 1) : base;
  endfunction

  function automatic logic [HALF_W-1:0] sck_half(input logic [1:0] rate, input logic dbl);
    logic [DIV_W-1:0] p;
    p = sck_period(rate, dbl);
    return p[DIV_W-1:1];
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/spi_sckgen.sv
module spi_sckgen #(
  parameter int HW    = 7,
  parameter int NEDGE = 16,
  localparam int EW   = $clog2(NEDGE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic          cpol,
  input  logic [HW-1:0] half_len,
  output logic          sck,
  output logic          busy,
  output logic          tick,
  output logic          lead,
  output logic          trail
);
  logic [HW-1:0] hcnt;
  logic [EW-1:0] ecnt;

  assign tick  = busy && (hcnt == half_len - HW'(1));
  assign lead  = tick && !ecnt[0];
  assign trail = tick &&  ecnt[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      hcnt <= '0;
      ecnt <= '0;
      sck  <= 1'b0;
    end else if (abort) begin
      busy <= 1'b0;
      hcnt <= '0;
      sck  <= cpol;
    end else if (start) begin
      busy <= 1'b1;
      hcnt <= '0;
      ecnt <= '0;
      sck  <= cpol;
    end else if (busy) begin
      if (tick) begin
        hcnt <= '0;
        sck  <= ~sck;
        ecnt <= ecnt + EW'(1);
        if (ecnt == EW'(NEDGE - 1)) busy <= 1'b0;
      end else begin
        hcnt <= hcnt + HW'(1);
      end
    end else begin
      sck <= cpol;
    end
  end
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int  DW = 8,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          clr,
  input  logic          lead,
  input  logic          trail,
  input  logic          cpha,
  input  logic          lsb_first,
  input  logic          in_bit,
  output logic          out_bit,
  output logic [DW-1:0] data,
  output logic          xfer_done
);
  logic [CW-1:0] cnt;
  logic          held;
  logic          sample_evt, setup_evt, mid_byte;

  function automatic logic [DW-1:0] shifted(input logic [DW-1:0] d, input logic b, input logic lsb);
    return lsb ? {b, d[DW-1:1]} : {d[DW-2:0], b};
  endfunction

  assign sample_evt = cpha ? trail : lead;
  assign setup_evt  = cpha ? lead  : trail;
  assign mid_byte   = (cnt != '0) && (cnt < CW'(DW));
  assign xfer_done  = sample_evt && (cnt == CW'(DW - 1));
  assign out_bit    = lsb_first ? data[0] : data[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      cnt  <= '0;
      held <= 1'b0;
    end else if (load) begin
      data <= load_data;
      cnt  <= '0;
    end else if (clr) begin
      cnt  <= '0;
    end else if (sample_evt) begin
      if (cnt == CW'(DW - 1)) begin
        data <= shifted(data, in_bit, lsb_first);
        cnt  <= CW'(DW);
      end else begin
        held <= in_bit;
        cnt  <= (cnt == CW'(DW)) ? CW'(1) : cnt + CW'(1);
      end
    end else if (setup_evt && mid_byte) begin
      data <= shifted(data, held, lsb_first);
    end
  end
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_ctrl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          sck_out,
  input  logic          sck_in,
  input  logic          ss_n_in,
  output logic          mosi_out,
  input  logic          mosi_in,
  output logic          miso_out,
  output logic          miso_oe,
  input  logic          miso_in
);
  spi_cfg_t cfg;
  logic     done_flag, wcol_flag, clr_armed;

  // synchronised pins
  logic sck_s, ss_s, mosi_s, sck_prev, ss_prev;
  spi_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sck_in, ss_n_in, mosi_in}),
    .q({sck_s, ss_s, mosi_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev <= 1'b1;
      ss_prev  <= 1'b1;
    end else begin
      sck_prev <= sck_s;
      ss_prev  <= ss_s;
    end
  end

  // named events
  logic is_master, slave_sel, ss_fall, s_edge, s_lead, s_trail, fault_evt;
  logic wr_cfg, wr_dat, rd_stat, rd_dat, clr_now;
  logic m_start, wcol_evt, m_sck, m_busy, m_tick, m_lead, m_trail;
  logic xfer_done, out_bit, sh_load, sh_clr;
  logic [DW-1:0]     sh_data;
  logic [HALF_W-1:0] half_len;

  assign is_master = cfg.master;
  assign slave_sel = !is_master && !ss_s;
  assign ss_fall   = ss_prev && !ss_s;
  assign s_edge    = slave_sel && (sck_s != sck_prev);
  assign s_lead    = s_edge && (sck_s != cfg.cpol);
  assign s_trail   = s_edge && (sck_s == cfg.cpol);
  assign fault_evt = is_master && !ss_s;

  assign wr_cfg  = wr_en && (reg_addr == ADDR_CFG);
  assign wr_dat  = wr_en && (reg_addr == ADDR_DATA);
  assign rd_stat = rd_en && (reg_addr == ADDR_STAT);
  assign rd_dat  = rd_en && (reg_addr == ADDR_DATA);
  assign clr_now = clr_armed && (wr_dat || rd_dat);

  assign m_start  = wr_dat && is_master && !m_busy && !fault_evt;
  assign wcol_evt = wr_dat && is_master && m_busy;
  assign half_len = sck_half(cfg.rate, cfg.dbl);
  assign sh_load  = wr_dat && !(is_master && m_busy);
  assign sh_clr   = !is_master && (ss_s || ss_fall);

  spi_sckgen #(.HW(HALF_W), .NEDGE(2 * DW)) u_sckgen (
    .clk(clk), .rst_n(rst_n),
    .start(m_start), .abort(fault_evt),
    .cpol(cfg.cpol), .half_len(half_len),
    .sck(m_sck), .busy(m_busy), .tick(m_tick),
    .lead(m_lead), .trail(m_trail)
  );

  spi_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(sh_load), .load_data(wr_data), .clr(sh_clr),
    .lead(is_master ? m_lead : s_lead),
    .trail(is_master ? m_trail : s_trail),
    .cpha(cfg.cpha), .lsb_first(cfg.lsb_first),
    .in_bit(is_master ? miso_in : mosi_s),
    .out_bit(out_bit), .data(sh_data), .xfer_done(xfer_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg       <= '0;
      done_flag <= 1'b0;
      wcol_flag <= 1'b0;
      clr_armed <= 1'b0;
    end else begin
      if (wr_cfg)         cfg        <= spi_cfg_t'(wr_data[CFG_W-1:0]);
      else if (fault_evt) cfg.master <= 1'b0;

      if (xfer_done || fault_evt) done_flag <= 1'b1;
      else if (clr_now)           done_flag <= 1'b0;

      if (wcol_evt)     wcol_flag <= 1'b1;
      else if (clr_now) wcol_flag <= 1'b0;

      if (rd_stat && (done_flag || wcol_flag)) clr_armed <= 1'b1;
      else if (clr_now)                       clr_armed <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_CFG:  rd_data = DW'(cfg);
      ADDR_STAT: rd_data = {done_flag, wcol_flag, (DW - 2)'(0)};
      ADDR_DATA: rd_data = sh_data;
      default:   rd_data = '0;
    endcase
  end

  assign sck_out  = is_master ? m_sck : cfg.cpol;
  assign mosi_out = is_master && out_bit;
  assign miso_out = out_bit;
  assign miso_oe  = slave_sel;

endmodule

// File: rtl/spi_ctrl_chk.sv
module spi_ctrl_chk #(
  parameter int HW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sck_out,
  input logic          cpol,
  input logic          cfg_master,
  input logic          m_busy,
  input logic          m_tick,
  input logic          m_start,
  input logic [HW-1:0] half_len,
  input logic          wr_dat,
  input logic          wcol_flag,
  input logic          fault_evt,
  input logic          done_flag,
  input logic          xfer_done,
  input logic          ss_n_in,
  input logic          miso_oe
);
  // clocks since the last start or SCK edge of the master generator
  logic [HW:0] gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gap <= '0;
    else if (m_start || m_tick) gap <= (HW + 1)'(1);
    else if (gap != '1)        gap <= gap + (HW + 1)'(1);
  end

  p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_busy && $past(!m_busy) && $past(cpol) == cpol && $past(cpol, 2) == cpol)
      |-> $stable(sck_out));

  p_half_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tick && m_busy) |-> (gap == {1'b0, half_len}));

  p_done_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> done_flag);

  p_collision_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && cfg_master && m_busy) |=> wcol_flag);

  p_mode_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> (!cfg_master && done_flag));

  p_quiet_slave_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_n_in && $past(ss_n_in) && $past(ss_n_in, 2)) |-> !miso_oe);

endmodule

bind spi_ctrl spi_ctrl_chk #(.HW(spi_ctrl_pkg::HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck_out(sck_out), .cpol(cfg.cpol),
  .cfg_master(cfg.master), .m_busy(m_busy), .m_tick(m_tick),
  .m_start(m_start), .half_len(half_len), .wr_dat(wr_dat),
  .wcol_flag(wcol_flag), .fault_evt(fault_evt), .done_flag(done_flag),
  .xfer_done(xfer_done), .ss_n_in(ss_n_in), .miso_oe(miso_oe)
);

// File: tb/sim_spi_ctrl.sv
module sim_spi_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SHP = 8;  // slave half-period in clocks

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0, rd_data;
  logic       sck_out, sck_in = 1'b0, ss_n_in = 1'b1;
  logic       mosi_out, mosi_in = 1'b0, miso_out, miso_oe, miso_in = 1'b0;

  int n_chk = 0, n_bad = 0;

  spi_ctrl u0 (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int period_of(input logic [1:0] rate, input logic dbl);
    int p;
    p = (rate == 0) ? 4 : (rate == 1) ? 16 : (rate == 2) ? 64 : 128;
    return dbl ? p / 2 : p;
  endfunction

  function automatic int pos(input int k, input logic lsb);
    return lsb ? k : 7 - k;
  endfunction

  function automatic logic [7:0] mk_cfg(input logic dbl, input logic [1:0] rate, input logic cpha,
                                        input logic cpol, input logic mst, input logic lsb);
    return {1'b0, dbl, rate, cpha, cpol, mst, lsb};
  endfunction

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // slave model for master-mode transfers
  logic       mon_on = 1'b0, mon_cpol, mon_cpha, mon_lsb, mon_prev_sck, mon_mosi_prev;
  logic [7:0] mon_tx, mon_rx;
  int         mon_edges, mon_sbits, mon_rbits, mon_gap, mon_min, mon_max;

  always @(negedge clk) begin
    if (mon_on) begin
      mon_gap++;
      if (sck_out != mon_prev_sck) begin
        mon_edges++;
        if (mon_edges > 1) begin
          if (mon_gap < mon_min) mon_min = mon_gap;
          if (mon_gap > mon_max) mon_max = mon_gap;
        end
        mon_gap = 0;
        if ((sck_out != mon_cpol) != mon_cpha) begin
          if (mon_rbits < 8) mon_rx[pos(mon_rbits, mon_lsb)] = mon_mosi_prev;
          mon_rbits++;
        end else if (mon_cpha) begin
          if (mon_sbits < 8) miso_in = mon_tx[pos(mon_sbits, mon_lsb)];
          mon_sbits++;
        end else begin
          mon_sbits++;
          if (mon_sbits < 8) miso_in = mon_tx[pos(mon_sbits, mon_lsb)];
        end
      end
      mon_prev_sck  = sck_out;
      mon_mosi_prev = mosi_out;
    end
  end

  task automatic run_master(input logic dbl, input logic [1:0] rate, input logic cpha, input logic cpol,
                            input logic lsb, input logic [7:0] tx, input logic [7:0] rx, input logic collide);
    int half;
    logic [7:0] v;
    half = period_of(rate, dbl) / 2;
    reg_wr(0, mk_cfg(dbl, rate, cpha, cpol, 1'b1, lsb));
    @(negedge clk);
    chk("R3 idle SCK before transfer", sck_out, cpol);
    mon_cpol = cpol; mon_cpha = cpha; mon_lsb = lsb; mon_tx = rx; mon_rx = '0;
    mon_edges = 0; mon_sbits = 0; mon_rbits = 0; mon_gap = 0; mon_min = 1000; mon_max = 0;
    mon_prev_sck = sck_out; mon_mosi_prev = mosi_out;
    miso_in = cpha ? 1'b0 : rx[pos(0, lsb)];
    mon_on = 1'b1;
    reg_wr(2, tx);
    if (collide) begin
      repeat (3) @(negedge clk);
      reg_wr(2, ~tx);
    end
    repeat (16 * half + 8) @(negedge clk);
    mon_on = 1'b0;
    chk("R5 SCK edge count", mon_edges, 16);
    chk("R5/R6 shortest half-period", mon_min, half);
    chk("R5/R6 longest half-period", mon_max, half);
    chk("R2/R4 byte seen on MOSI", mon_rx, tx);
    chk("R3 idle SCK after transfer", sck_out, cpol);
    reg_rd(1, v);
    chk(collide ? "R8 status with collision" : "R7 status after transfer", v, collide ? 8'hC0 : 8'h80);
    reg_rd(2, v);
    chk("R2/R4 byte received from MISO", v, rx);
    reg_rd(1, v);
    chk("R7 status cleared by read sequence", v, 8'h00);
  endtask

  task automatic run_slave(input logic dbl, input logic [1:0] rate, input logic cpha, input logic cpol,
                           input logic lsb, input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] got, v;
    reg_wr(0, mk_cfg(dbl, rate, cpha, cpol, 1'b0, lsb));
    reg_wr(2, tx);
    sck_in = cpol;
    mosi_in = cpha ? 1'b0 : rx[pos(0, lsb)];
    repeat (4) @(negedge clk);
    ss_n_in = 1'b0;
    repeat (6) @(negedge clk);
    chk("R10 MISO enabled while selected", miso_oe, 1);
    if (!cpha) chk("R11 first bit on MISO before SCK", miso_out, tx[pos(0, lsb)]);
    got = '0;
    for (int k = 0; k < 8; k++) begin
      if (cpha) begin
        sck_in = ~cpol; mosi_in = rx[pos(k, lsb)];
        repeat (SHP) @(negedge clk);
        got[pos(k, lsb)] = miso_out;
        sck_in = cpol;
        repeat (SHP) @(negedge clk);
      end else begin
        got[pos(k, lsb)] = miso_out;
        sck_in = ~cpol;
        repeat (SHP) @(negedge clk);
        sck_in = cpol;
        if (k < 7) mosi_in = rx[pos(k + 1, lsb)];
        repeat (SHP) @(negedge clk);
      end
    end
    repeat (4) @(negedge clk);
    ss_n_in = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6/R11 slave byte sent on MISO", got, tx);
    chk("R10 MISO released after deselect", miso_oe, 0);
    reg_rd(1, v);
    chk("R7 slave status after transfer", v, 8'h80);
    reg_rd(2, v);
    chk("R6 slave byte received from MOSI", v, rx);
    reg_rd(1, v);
    chk("R7 slave status cleared", v, 8'h00);
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 SCK after reset", sck_out, 0);
    chk("R1 MOSI after reset", mosi_out, 0);
    chk("R1 MISO enable after reset", miso_oe, 0);
    reg_rd(0, v); chk("R1 configuration after reset", v, 8'h00);
    reg_rd(1, v); chk("R1 status after reset", v, 8'h00);

    // directed master corners: all modes at the fastest rate, and the slowest rate
    run_master(1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C, 1'b0);
    run_master(1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 8'h81, 8'h7E, 1'b0);
    run_master(1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 8'h01, 8'hF0, 1'b0);
    run_master(1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 8'hFF, 8'h00, 1'b0);
    run_master(1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 8'h5A, 8'hC3, 1'b0);
    run_master(1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 8'h96, 8'h69, 1'b1);  // R8

    // random master transfers
    for (int i = 0; i < 10; i++) begin
      logic [6:0] r;
      r = 7'($urandom);
      run_master(r[6], r[5:4], r[3], r[2], r[0], 8'($urandom), 8'($urandom), 1'b0);
    end

    // R10: slave ignores SCK while deselected
    reg_wr(0, mk_cfg(1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0));
    reg_wr(2, 8'hC9);
    for (int k = 0; k < 8; k++) begin
      sck_in = 1'b1; mosi_in = k[0];
      repeat (SHP) @(negedge clk);
      chk("R10 MISO stays released while deselected", miso_oe, 0);
      sck_in = 1'b0;
      repeat (SHP) @(negedge clk);
    end
    reg_rd(1, v); chk("R10 no completion while deselected", v, 8'h00);
    reg_rd(2, v); chk("R10 data untouched while deselected", v, 8'hC9);

    // R10: partial transfer aborted, then a clean one
    ss_n_in = 1'b0;
    repeat (6) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      sck_in = 1'b1; repeat (SHP) @(negedge clk);
      sck_in = 1'b0; repeat (SHP) @(negedge clk);
    end
    ss_n_in = 1'b1;
    repeat (6) @(negedge clk);
    reg_rd(1, v); chk("R10 aborted partial sets no completion", v, 8'h00);
    run_slave(1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 8'h4D, 8'hB2);

    // directed and random slave transfers
    run_slave(1'b1, 2'd3, 1'b1, 1'b1, 1'b1, 8'h12, 8'hED);
    for (int i = 0; i < 6; i++) begin
      logic [6:0] r;
      r = 7'($urandom);
      run_slave(r[6], r[5:4], r[3], r[2], r[0], 8'($urandom), 8'($urandom));
    end

    // R9: mode fault
    reg_wr(0, mk_cfg(1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0));
    reg_rd(0, v); chk("R9 master bit set before fault", v[1], 1);
    ss_n_in = 1'b0;
    repeat (5) @(negedge clk);
    reg_rd(0, v); chk("R9 master bit cleared by fault", v[1], 0);
    reg_rd(1, v); chk("R9 completion flag raised by fault", v, 8'h80);
    reg_rd(2, v);
    ss_n_in = 1'b1;
    repeat (4) @(negedge clk);
    reg_rd(1, v); chk("R9 fault flag cleared by read sequence", v, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule